// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into a maskable interrupt request for a processor core. The pin passes through a multi-stage synchronizer, and a high-to-low transition of the synchronized level sets a request latch. A request output, gated by a mask bit, goes to the core. The core clears the latch with a vector-fetch acknowledge pulse. Software can also clear it by writing a one to a write-only acknowledge bit in a small control/status register.

A mode bit picks one of two kinds of sensitivity. In edge mode an acknowledge clears the latch at once. In level mode the latch is also held while the pin stays low. It clears only after an acknowledge has been seen and the pin is high again, and these two events may come in either order. Software can poll the pending flag whether or not the request is masked. The register also drives a pull-up disable output toward the pad.

Top module: `xirq_ctrl`

## Requirements
- R1: Reset clears the latch, the mode bit, the mask bit and the pull-up bit. After reset the register reads all zeros, `irq_req` is 0 and `pullup_dis` is 0. This holds even when the pin is held low through and after reset.
- R2: When `pin_n` goes from 1 to 0, with the default two synchronizer stages, the pending flag reads 1 after the third rising clock edge.
- R3: In edge mode (bit 0 = 0), a `vec_ack` pulse or a register write with bit 2 = 1 clears the pending flag on the next edge, even while the pin is still low.
- R4: In level mode (bit 0 = 1), a low synchronized pin sets and holds the pending flag. This happens without any falling edge, and an acknowledge does not clear the flag while the pin is low.
- R5: In level mode, the pending flag clears once an acknowledge has occurred and the pin is high. This works with the acknowledge before the pin returns high, and with the pin high before the acknowledge.
- R6: `irq_req` equals pending AND NOT mask (mask is bit 1). The pending flag (bit 3, read-only) reads the same whether or not the request is masked.
- R7: If a falling edge is detected in the same cycle as an acknowledge, the latch stays set.
- R8: The acknowledge bit (bit 2) always reads 0. A falling edge that follows an acknowledge sets a new request.
- R9: Register bit 4 is the pull-up disable bit. It reads back as written and drives `pullup_dis`.
- R10: Register bits 0, 1 and 4 are read/write. Bit 3 is read-only and bit 2 is write-only. All bits above 4 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle vector-fetch acknowledge from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq_req | output | 1 | Masked interrupt request to the core |
| pullup_dis | output | 1 | Pull-up disable toward the pad |

## Verification
The assertions assume that `vec_ack` and the acknowledge write are single-cycle pulses sampled at the clock edge. They also assume the pin is asynchronous, and they reason only about its synchronized value, never about the raw input. The stimulus changes `pin_n` only on falling clock edges. It holds each pin level for at least four cycles before an acknowledge, so every edge has passed through the synchronizer. The one exception is the same-cycle collision case, where the acknowledge is placed on the exact cycle the edge is detected.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   // register field positions
   localparam int F_MODE  = 0;   // 1 = edge plus level sensitivity
   localparam int F_MASK  = 1;   // 1 = request masked
   localparam int F_ACK   = 2;   // write-one acknowledge, reads 0
   localparam int F_PEND  = 3;   // latch state, read-only
   localparam int F_PUOFF = 4;   // pull-up disable
   localparam int F_USED  = 5;   // number of defined bits
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad
         $error("xirq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[0] <= 1'b0;
               else        sr[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[i] <= 1'b0;
               else        sr[i] <= sr[i-1];
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/xirq_csr.sv
module xirq_csr
   import xirq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit LEVEL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pend,
   output logic              mode,
   output logic              mask,
   output logic              puoff,
   output logic              sw_ack,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (DATA_W < F_USED) begin : g_bad
         $error("xirq_csr: DATA_W too small for the field layout");
      end
      if (LEVEL_EN) begin : g_mode
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)  mode <= 1'b0;
            else if (wr) mode <= wdata[F_MODE];
      end else begin : g_nomode
         assign mode = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= 1'b0;
         puoff <= 1'b0;
      end else if (wr) begin
         mask  <= wdata[F_MASK];
         puoff <= wdata[F_PUOFF];
      end
   end

   assign sw_ack = wr & wdata[F_ACK];

   always_comb begin
      rdata          = '0;
      rdata[F_MODE]  = mode;
      rdata[F_MASK]  = mask;
      rdata[F_PEND]  = pend;
      rdata[F_PUOFF] = puoff;
   end
endmodule

// File: rtl/xirq_latch.sv
module xirq_latch #(
   parameter bit LEVEL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic mode,
   input  logic ack,
   output logic fall,
   output logic pend
);
   logic prev_q;
   logic seen_q, seen_d;
   logic pend_d;
   logic level_hold;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;

   assign fall = prev_q & ~pin_s;

   generate
      if (LEVEL_EN) begin : g_level
         assign level_hold = mode & ~pin_s;
      end else begin : g_edge
         assign level_hold = 1'b0;
      end
   endgenerate

   always_comb begin
      pend_d = pend;
      seen_d = seen_q;
      if (fall || level_hold) begin
         pend_d = 1'b1;
         if (fall)                seen_d = 1'b0;
         else if (ack && pend)    seen_d = 1'b1;
      end else if (mode) begin
         if (ack || seen_q) begin
            pend_d = 1'b0;
            seen_d = 1'b0;
         end
      end else begin
         seen_d = 1'b0;
         if (ack) pend_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         pend   <= pend_d;
         seen_q <= seen_d;
      end
   end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LEVEL_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_n,
   input  logic              vec_ack,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic              pullup_dis
);
   logic pin_sync;
   logic mode, mask, sw_ack, ack_any, fall_det, pend;

   xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_sync)
   );

   xirq_csr #(.DATA_W(DATA_W), .LEVEL_EN(LEVEL_EN)) u_csr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .pend(pend), .mode(mode), .mask(mask), .puoff(pullup_dis),
      .sw_ack(sw_ack), .rdata(reg_rdata)
   );

   assign ack_any = vec_ack | sw_ack;

   xirq_latch #(.LEVEL_EN(LEVEL_EN)) u_latch (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_sync), .mode(mode),
      .ack(ack_any), .fall(fall_det), .pend(pend)
   );

   assign irq_req = pend & ~mask;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
   import xirq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic              pullup_dis,
   input logic [DATA_W-1:0] rdata,
   input logic              ack,
   input logic              fall,
   input logic              pin_now
);
   // R6: request only when pending and unmasked
   a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (rdata[F_PEND] && !rdata[F_MASK]));
   // R6: pending and unmasked always raises the request
   a_r6_req_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[F_PEND] && !rdata[F_MASK]) |-> irq_req);
   // R2, R7: a detected edge sets the latch, acknowledge or not
   a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> rdata[F_PEND]);
   // R3: edge mode acknowledge without a new edge clears
   a_r3_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdata[F_MODE] && ack && !fall) |=> !rdata[F_PEND]);
   // R4: level mode with a low pin keeps the request
   a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[F_MODE] && !pin_now) |=> rdata[F_PEND]);
   // R8: acknowledge bit never reads back
   a_r8_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata[F_ACK]);
   // R9: pad control follows the register bit
   a_r9_pullup_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_dis == rdata[F_PUOFF]);
   // R10: undefined bits read zero
   a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:F_USED] == '0);
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pullup_dis(pullup_dis),
   .rdata(reg_rdata), .ack(ack_any), .fall(fall_det), .pin_now(pin_sync)
);

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_n = 1'b1;
   logic       vec_ack = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_req, pullup_dis;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   xirq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .vec_ack(vec_ack),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .pullup_dis(pullup_dis)
   );

   // {mode, mask, pin, vec_ack, sw_ack, exp_pend, exp_irq}
   localparam logic [6:0] VEC [13] = '{
      7'b0010000, 7'b0000011, 7'b0001000, 7'b0010000,
      7'b0100010, 7'b0100100, 7'b1010000, 7'b1000011,
      7'b1001011, 7'b1010000, 7'b1000011, 7'b1010011,
      7'b1010100
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] d, input logic va);
      reg_wr = 1'b1; reg_wdata = d; vec_ack = va;
      tick(1);
      reg_wr = 1'b0; reg_wdata = '0; vec_ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      tick(3);
      // R1: reset state
      check("R1 rdata", reg_rdata, 8'h00);
      check("R1 irq", irq_req, 1'b0);
      rst_n = 1'b1;
      tick(2);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < 13; i++) begin
         logic [6:0] v;
         v = VEC[i];
         pin_n = v[4];
         tick(4);
         wr_reg({5'b0, v[2], v[5], v[6]}, v[3]);
         tick(2);
         check($sformatf("R2 R3 R4 R5 R6 vector %0d pend", i), reg_rdata[3], v[1]);
         check($sformatf("R6 vector %0d irq", i), irq_req, v[0]);
      end

      // R7: edge and acknowledge in the same cycle
      wr_reg(8'h00, 1'b0);
      pin_n = 1'b0; tick(4);
      pin_n = 1'b1; tick(4);
      check("R7 setup pend", reg_rdata[3], 1'b1);
      pin_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      wr_reg(8'h04, 1'b1);
      tick(1);
      check("R7 edge wins", reg_rdata[3], 1'b1);

      // R8: ack reads zero, new edge after ack
      wr_reg(8'h04, 1'b0);
      check("R8 ack bit reads 0", reg_rdata[2], 1'b0);
      check("R3 cleared pin low", reg_rdata[3], 1'b0);
      pin_n = 1'b1; tick(4);
      pin_n = 1'b0; tick(4);
      check("R8 new edge after ack", reg_rdata[3], 1'b1);
      wr_reg(8'h04, 1'b0);

      // R9, R10: pull-up control and read-back
      wr_reg(8'hF2, 1'b0);
      check("R9 pullup_dis", pullup_dis, 1'b1);
      check("R10 readback", reg_rdata, 8'h12);
      wr_reg(8'h00, 1'b0);
      check("R9 pullup_dis off", pullup_dis, 1'b0);

      // R1: reset with level mode and pin held low
      wr_reg(8'h01, 1'b0);
      tick(2);
      check("R4 level set without edge", reg_rdata[3], 1'b1);
      rst_n = 1'b0; tick(3);
      rst_n = 1'b1; tick(5);
      check("R1 reset with pin low rdata", reg_rdata, 8'h00);
      check("R1 reset with pin low irq", irq_req, 1'b0);

      // R5: pin returns high before the acknowledge, in level mode
      wr_reg(8'h01, 1'b0);
      tick(2);
      pin_n = 1'b1; tick(4);
      check("R5 held until ack", reg_rdata[3], 1'b1);
      wr_reg(8'h05, 1'b0);
      tick(1);
      check("R5 cleared after ack", reg_rdata[3], 1'b0);

      done = 1'b1;
      finish_run();
   end
endmodule